// File: doc/BRIEF.md
# VM-Entry Control Consistency Checker

This block decides whether a set of virtual-machine execution control fields is self-consistent before a guest entry goes ahead. A caller presents the primary and secondary control words, the reserved-bit masks, the CR3-target count, five table addresses, the task-priority threshold field, the virtual task-priority byte, the physical-address width and a flag that limits addresses to 32 bits. It then pulses `start`. The block samples all inputs on that edge and steps through thirteen rules in a fixed order, one rule per clock.

The block stops at the first rule that is broken. It then pulses `done` with `pass` low and puts that rule's index on `err_code`. If every rule holds, `done` pulses after the thirteenth rule with `pass` high and a code of zero. `pass` and `err_code` keep their values until the next check finishes.

Control bit positions used by the rules:
- Primary word: NMI exiting at bit 3, virtual NMIs at bit 5, TPR shadow at bit 21, NMI-window exiting at bit 22, I/O bitmaps at bit 25, MSR bitmaps at bit 28, secondary-enable at bit 31.
- Secondary word: APIC-access virtualization at bit 0, x2APIC virtualization at bit 4, APIC-register virtualization at bit 8, virtual-interrupt delivery at bit 9.

Top module: `vmentry_ctl_chk`

## Requirements
- R1: After reset, `done`, `pass` and `err_code` are 0. A `start` taken in the idle state gives a one-cycle `done` exactly k clocks later when rule k fails, or 13 clocks later when all rules hold.
- R2: `pass` is 1 with `err_code` 0 only when all rules hold. Otherwise `err_code` is the lowest-numbered failing rule: 1 primary reserved, 2 secondary reserved, 3 CR3 count, 4 I/O bitmap A, 5 I/O bitmap B, 6 MSR bitmap, 7 virtual-APIC address, 8 threshold upper bits, 9 threshold versus virtual TPR, 10 virtual NMIs, 11 NMI-window, 12 APIC-access address, 13 TPR-shadow dependents.
- R3: Rule 1 fails when a bit set in `pri_must1` is clear in the primary word, or when a bit set in `pri_must0` is set in the primary word.
- R4: When primary bit 31 is 0, the secondary word is ignored. Rule 2 is skipped, and every other rule sees all secondary controls as 0.
- R5: When primary bit 31 is 1, rule 2 fails if the secondary word and `sec_rsvd` share any set bit.
- R6: Rule 3 fails when `cr3_cnt` is greater than 4.
- R7: Each address rule applies only when its enable is set: I/O bitmaps (rules 4 and 5), MSR bitmaps (rule 6), TPR shadow (rule 7), effective APIC-access virtualization (rule 12). An enabled address fails if any of bits 11:0 is set, or if any bit at or above `paw` is set.
- R8: When `addr32` is 1, an enabled address with any bit set in 63:32 fails its rule.
- R9: Rule 8 fails when TPR shadow is 1, effective virtual-interrupt delivery is 0, and any of `tpr_thresh[31:4]` is set.
- R10: Rule 9 fails when TPR shadow is 1, effective APIC-access virtualization and virtual-interrupt delivery are both 0, and `tpr_thresh[3:0]` is greater than `vtpr[7:4]`.
- R11: Rule 10 fails when virtual NMIs is set while NMI exiting is clear. Rule 11 fails when NMI-window exiting is set while virtual NMIs is clear.
- R12: Rule 13 fails when TPR shadow is 0 and any effective x2APIC virtualization, APIC-register virtualization or virtual-interrupt delivery bit is set.
- R13: A `start` while a check is running is ignored. Input changes after the start edge do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check (taken only when idle) |
| pri_ctl | input | 32 | Primary control word |
| sec_ctl | input | 32 | Secondary control word |
| pri_must1 | input | 32 | Primary bits that must be one |
| pri_must0 | input | 32 | Primary bits that must be zero |
| sec_rsvd | input | 32 | Reserved secondary bits |
| cr3_cnt | input | 9 | CR3-target count |
| io_a_addr | input | 64 | I/O bitmap A address |
| io_b_addr | input | 64 | I/O bitmap B address |
| msr_addr | input | 64 | MSR bitmap address |
| vapic_addr | input | 64 | Virtual-APIC page address |
| apic_acc_addr | input | 64 | APIC-access page address |
| tpr_thresh | input | 32 | TPR threshold field |
| vtpr | input | 8 | Virtual TPR byte |
| paw | input | 6 | Physical-address width, 32 to 52 |
| addr32 | input | 1 | Limit enabled addresses to 32 bits |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | All rules held in the last check |
| err_code | output | 4 | First failing rule, 0 on pass |

## Verification
The properties that tie a passing result to input values assume that the control inputs stay unchanged from the start edge until `done`. The bench applies every vector before `start` and holds it until completion. The one exception is the test that changes inputs mid-check. That test is built to end in a failure, and the input-linked properties only look at passing results. `paw` is always driven between 32 and 52.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
    localparam int CTL_W     = 32;
    localparam int NUM_RULES = 13;
    localparam int ERR_W     = $clog2(NUM_RULES + 1);
    localparam int N_ADDR    = 5;

    // primary control bit positions
    localparam int P_NMI_EXIT = 3;
    localparam int P_VIRT_NMI = 5;
    localparam int P_TPR_SHAD = 21;
    localparam int P_NMI_WIN  = 22;
    localparam int P_IO_BMP   = 25;
    localparam int P_MSR_BMP  = 28;
    localparam int P_SEC_EN   = 31;

    // secondary control bit positions
    localparam int S_APIC_ACC = 0;
    localparam int S_X2APIC   = 4;
    localparam int S_APIC_REG = 8;
    localparam int S_VINTR    = 9;

    typedef enum logic [ERR_W-1:0] {
        RULE_NONE      = 4'd0,
        RULE_PRI_RSVD  = 4'd1,
        RULE_SEC_RSVD  = 4'd2,
        RULE_CR3_CNT   = 4'd3,
        RULE_IO_A      = 4'd4,
        RULE_IO_B      = 4'd5,
        RULE_MSR       = 4'd6,
        RULE_VAPIC     = 4'd7,
        RULE_THR_HI    = 4'd8,
        RULE_THR_VTPR  = 4'd9,
        RULE_VNMI      = 4'd10,
        RULE_NMI_WIN   = 4'd11,
        RULE_APIC_ACC  = 4'd12,
        RULE_TPR_DEPS  = 4'd13
    } rule_e;

    // rule index reported by each address checker slot
    localparam rule_e ADDR_RULE [N_ADDR] =
        '{RULE_IO_A, RULE_IO_B, RULE_MSR, RULE_VAPIC, RULE_APIC_ACC};

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_e;

    typedef struct packed {
        run_e                 st;
        logic [ERR_W-1:0]     idx;
        logic [NUM_RULES:1]   fails;
        logic                 done;
        logic                 pass;
        logic [ERR_W-1:0]     code;
    } chk_state_t;
endpackage

// File: rtl/vmc_addr_rule.sv
module vmc_addr_rule #(
    parameter int ADDR_W   = 64,
    parameter int PAW_W    = 6,
    parameter int LOW_ZERO = 12,
    parameter int NARROW_W = 32
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAW_W-1:0]  paw,
    input  logic              lim32,
    output logic              bad
);
    localparam int CMP_W = $clog2(ADDR_W) + 2;

    logic [ADDR_W-1:0] beyond_mask;
    logic              low_bad;
    logic              wide_bad;
    logic              narrow_bad;

    // one mask bit per address bit: set when the bit is at or above the width
    for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
        assign beyond_mask[g] = (CMP_W'(g) >= CMP_W'(paw));
    end

    assign low_bad    = |addr[LOW_ZERO-1:0];
    assign wide_bad   = |(addr & beyond_mask);
    assign narrow_bad = lim32 & (|addr[ADDR_W-1:NARROW_W]);
    assign bad        = en & (low_bad | wide_bad | narrow_bad);
endmodule

// File: rtl/vmc_rule_eval.sv
module vmc_rule_eval
    import vmc_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int PAW_W   = 6,
    parameter int CR3_W   = 9,
    parameter int CR3_MAX = 4
) (
    input  logic [CTL_W-1:0]   pri_ctl,
    input  logic [CTL_W-1:0]   sec_ctl,
    input  logic [CTL_W-1:0]   pri_must1,
    input  logic [CTL_W-1:0]   pri_must0,
    input  logic [CTL_W-1:0]   sec_rsvd,
    input  logic [CR3_W-1:0]   cr3_cnt,
    input  logic [ADDR_W-1:0]  io_a_addr,
    input  logic [ADDR_W-1:0]  io_b_addr,
    input  logic [ADDR_W-1:0]  msr_addr,
    input  logic [ADDR_W-1:0]  vapic_addr,
    input  logic [ADDR_W-1:0]  apic_acc_addr,
    input  logic [CTL_W-1:0]   tpr_thresh,
    input  logic [7:0]         vtpr,
    input  logic [PAW_W-1:0]   paw,
    input  logic               addr32,
    output logic [NUM_RULES:1] fail
);
    logic              sec_on;
    logic [CTL_W-1:0]  sec_eff;
    logic              tpr_sh;
    logic              vid;
    logic              apic_acc;
    logic [ADDR_W-1:0] addr_arr [N_ADDR];
    logic [N_ADDR-1:0] addr_en;
    logic [N_ADDR-1:0] addr_bad;

    assign sec_on   = pri_ctl[P_SEC_EN];
    assign sec_eff  = sec_on ? sec_ctl : '0;
    assign tpr_sh   = pri_ctl[P_TPR_SHAD];
    assign vid      = sec_eff[S_VINTR];
    assign apic_acc = sec_eff[S_APIC_ACC];

    assign addr_arr[0] = io_a_addr;
    assign addr_arr[1] = io_b_addr;
    assign addr_arr[2] = msr_addr;
    assign addr_arr[3] = vapic_addr;
    assign addr_arr[4] = apic_acc_addr;
    assign addr_en     = {apic_acc, tpr_sh, pri_ctl[P_MSR_BMP],
                          pri_ctl[P_IO_BMP], pri_ctl[P_IO_BMP]};

    for (genvar a = 0; a < N_ADDR; a++) begin : g_addr
        vmc_addr_rule #(
            .ADDR_W (ADDR_W),
            .PAW_W  (PAW_W)
        ) u_addr (
            .en    (addr_en[a]),
            .addr  (addr_arr[a]),
            .paw   (paw),
            .lim32 (addr32),
            .bad   (addr_bad[a])
        );
    end

    always_comb begin
        fail = '0;
        fail[RULE_PRI_RSVD] = ((pri_ctl & pri_must1) != pri_must1)
                            || ((pri_ctl & pri_must0) != '0);
        fail[RULE_SEC_RSVD] = sec_on && ((sec_ctl & sec_rsvd) != '0);
        fail[RULE_CR3_CNT]  = (cr3_cnt > CR3_W'(CR3_MAX));
        for (int i = 0; i < N_ADDR; i++) begin
            fail[ADDR_RULE[i]] = addr_bad[i];
        end
        fail[RULE_THR_HI]   = tpr_sh && !vid && (tpr_thresh[CTL_W-1:4] != '0);
        fail[RULE_THR_VTPR] = tpr_sh && !vid && !apic_acc
                            && (tpr_thresh[3:0] > vtpr[7:4]);
        fail[RULE_VNMI]     = pri_ctl[P_VIRT_NMI] && !pri_ctl[P_NMI_EXIT];
        fail[RULE_NMI_WIN]  = pri_ctl[P_NMI_WIN] && !pri_ctl[P_VIRT_NMI];
        fail[RULE_TPR_DEPS] = !tpr_sh
                            && (sec_eff[S_X2APIC] || sec_eff[S_APIC_REG] || vid);
    end
endmodule

// File: rtl/vmentry_ctl_chk.sv
module vmentry_ctl_chk
    import vmc_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int PAW_W   = 6,
    parameter int CR3_W   = 9,
    parameter int CR3_MAX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       pri_ctl,
    input  logic [31:0]       sec_ctl,
    input  logic [31:0]       pri_must1,
    input  logic [31:0]       pri_must0,
    input  logic [31:0]       sec_rsvd,
    input  logic [CR3_W-1:0]  cr3_cnt,
    input  logic [ADDR_W-1:0] io_a_addr,
    input  logic [ADDR_W-1:0] io_b_addr,
    input  logic [ADDR_W-1:0] msr_addr,
    input  logic [ADDR_W-1:0] vapic_addr,
    input  logic [ADDR_W-1:0] apic_acc_addr,
    input  logic [31:0]       tpr_thresh,
    input  logic [7:0]        vtpr,
    input  logic [PAW_W-1:0]  paw,
    input  logic              addr32,
    output logic              done,
    output logic              pass,
    output logic [3:0]        err_code
);
    logic [NUM_RULES:1] fail_now;
    chk_state_t         r_d;
    chk_state_t         r_q;

    vmc_rule_eval #(
        .ADDR_W  (ADDR_W),
        .PAW_W   (PAW_W),
        .CR3_W   (CR3_W),
        .CR3_MAX (CR3_MAX)
    ) u_eval (
        .pri_ctl       (pri_ctl),
        .sec_ctl       (sec_ctl),
        .pri_must1     (pri_must1),
        .pri_must0     (pri_must0),
        .sec_rsvd      (sec_rsvd),
        .cr3_cnt       (cr3_cnt),
        .io_a_addr     (io_a_addr),
        .io_b_addr     (io_b_addr),
        .msr_addr      (msr_addr),
        .vapic_addr    (vapic_addr),
        .apic_acc_addr (apic_acc_addr),
        .tpr_thresh    (tpr_thresh),
        .vtpr          (vtpr),
        .paw           (paw),
        .addr32        (addr32),
        .fail          (fail_now)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_RUN;
                    r_d.idx   = ERR_W'(1);
                    r_d.fails = fail_now;
                end
            end
            ST_RUN: begin
                if (r_q.fails[r_q.idx]) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.pass = 1'b0;
                    r_d.code = r_q.idx;
                end else if (r_q.idx == ERR_W'(NUM_RULES)) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.pass = 1'b1;
                    r_d.code = RULE_NONE;
                end else begin
                    r_d.idx = r_q.idx + ERR_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, idx: '0, fails: '0, done: 1'b0,
                     pass: 1'b0, code: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done     = r_q.done;
    assign pass     = r_q.pass;
    assign err_code = r_q.code;
endmodule

// File: rtl/vmentry_ctl_chk_sva.sv
module vmentry_ctl_chk_sva
    import vmc_pkg::*;
#(
    parameter int CR3_W   = 9,
    parameter int CR3_MAX = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [31:0]      pri_ctl,
    input logic [CR3_W-1:0] cr3_cnt,
    input logic             done,
    input logic             pass,
    input logic [3:0]       err_code
);
    logic       busy_c;
    logic [4:0] cnt_c;

    // independent tracking of an in-flight check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_c <= 1'b0;
            cnt_c  <= '0;
        end else if (!busy_c || done) begin
            busy_c <= start;
            cnt_c  <= '0;
        end else begin
            cnt_c  <= cnt_c + 5'd1;
        end
    end

    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_in_flight_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_c);
    p_bounded_run_r13: assert property (@(posedge clk) disable iff (!rst_n)
        busy_c |-> cnt_c <= 5'(NUM_RULES));
    p_code_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass == (err_code == 4'd0)));
    p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> err_code <= 4'(NUM_RULES));
    p_cr3_on_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> cr3_cnt <= CR3_W'(CR3_MAX));
    p_nmi_on_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> !(pri_ctl[P_VIRT_NMI] && !pri_ctl[P_NMI_EXIT]));
    p_outputs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(err_code));
endmodule

bind vmentry_ctl_chk vmentry_ctl_chk_sva #(
    .CR3_W   (CR3_W),
    .CR3_MAX (CR3_MAX)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pri_ctl  (pri_ctl),
    .cr3_cnt  (cr3_cnt),
    .done     (done),
    .pass     (pass),
    .err_code (err_code)
);

// File: tb/vmentry_ctl_chk_tb_top.sv
`timescale 1ns/1ps
module vmentry_ctl_chk_tb_top;
    typedef struct packed {
        logic [31:0] pri;
        logic [31:0] sec;
        logic [8:0]  cr3;
        logic [63:0] io_a;
        logic [63:0] io_b;
        logic [63:0] msr;
        logic [63:0] vapic;
        logic [63:0] apic;
        logic [31:0] thr;
        logic [7:0]  vt;
        logic [5:0]  pw;
        logic        lim;
        logic [3:0]  exp_code;
    } vec_t;

    localparam logic [31:0] PB   = 32'h9260_0028; // sec, msr, io, nmiwin, tpr, vnmi, nmiexit
    localparam logic [63:0] A1   = 64'h1000;
    localparam logic [63:0] A2   = 64'h2000;
    localparam logic [63:0] A3   = 64'h3000;
    localparam logic [63:0] A4   = 64'h4000;
    localparam logic [63:0] A5   = 64'h5000;
    localparam logic [63:0] HI32 = 64'h1_0000_0000;
    localparam int NV = 20;

    localparam vec_t VEC [NV] = '{
        '{PB, 32'h0, 9'd4, A1, A2, A3, A4, A5, 32'h3, 8'h40, 6'd36, 1'b0, 4'd0},
        '{PB, 32'h0, 9'd5, A1, A2, A3, A4, A5, 32'h3, 8'h40, 6'd36, 1'b0, 4'd3},
        '{PB, 32'h0, 9'd4, 64'h1004, A2, A3, A4, A5, 32'h3, 8'h40, 6'd36, 1'b0, 4'd4},
        '{PB, 32'h0, 9'd4, A1, 64'h10_0000_0000, A3, A4, A5, 32'h3, 8'h40, 6'd36, 1'b0, 4'd5},
        '{PB, 32'h0, 9'd4, A1, A2, HI32, A4, A5, 32'h3, 8'h40, 6'd36, 1'b1, 4'd6},
        '{PB, 32'h0, 9'd4, A1, A2, HI32, A4, A5, 32'h3, 8'h40, 6'd36, 1'b0, 4'd0},
        '{PB, 32'h0, 9'd4, A1, A2, A3, 64'h4800, A5, 32'h3, 8'h40, 6'd36, 1'b0, 4'd7},
        '{PB, 32'h0, 9'd4, A1, A2, A3, A4, A5, 32'h13, 8'h40, 6'd36, 1'b0, 4'd8},
        '{PB, 32'h0, 9'd4, A1, A2, A3, A4, A5, 32'h5, 8'h40, 6'd36, 1'b0, 4'd9},
        '{PB, 32'h0, 9'd4, A1, A2, A3, A4, A5, 32'h4, 8'h40, 6'd36, 1'b0, 4'd0},
        '{32'h9260_0020, 32'h0, 9'd4, A1, A2, A3, A4, A5, 32'h3, 8'h40, 6'd36, 1'b0, 4'd10},
        '{32'h9260_0008, 32'h0, 9'd4, A1, A2, A3, A4, A5, 32'h3, 8'h40, 6'd36, 1'b0, 4'd11},
        '{PB, 32'h1, 9'd4, A1, A2, A3, A4, 64'h5001, 32'h5, 8'h40, 6'd36, 1'b0, 4'd12},
        '{32'h9240_0028, 32'h200, 9'd4, A1, A2, A3, 64'h4001, A5, 32'h3, 8'h40, 6'd36, 1'b0, 4'd13},
        '{32'h1260_0028, 32'hFFFF_FFFF, 9'd4, A1, A2, A3, A4, 64'h5001, 32'h5, 8'h40, 6'd36, 1'b0, 4'd9},
        '{PB, 32'h0001_0000, 9'd4, A1, A2, A3, A4, A5, 32'h3, 8'h40, 6'd36, 1'b0, 4'd2},
        '{PB, 32'h0, 9'd9, 64'h1004, A2, A3, A4, A5, 32'h3, 8'h40, 6'd36, 1'b0, 4'd3},
        '{32'h9060_0028, 32'h0, 9'd4, 64'h1234, 64'h7, A3, A4, A5, 32'h3, 8'h40, 6'd36, 1'b0, 4'd0},
        '{PB, 32'h0, 9'd4, 64'h0008_0000_0000_0000, A2, HI32, A4, A5, 32'h3, 8'h40, 6'd52, 1'b0, 4'd0},
        '{PB, 32'h200, 9'd4, A1, A2, HI32, A4, A5, 32'h100, 8'h00, 6'd32, 1'b0, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] pri_ctl = '0, sec_ctl = '0, pri_must1 = '0, pri_must0 = '0;
    logic [31:0] sec_rsvd = 32'hFFFF_0000;
    logic [8:0]  cr3_cnt = '0;
    logic [63:0] io_a_addr = '0, io_b_addr = '0, msr_addr = '0;
    logic [63:0] vapic_addr = '0, apic_acc_addr = '0;
    logic [31:0] tpr_thresh = '0;
    logic [7:0]  vtpr = '0;
    logic [5:0]  paw = 6'd36;
    logic        addr32 = 1'b0;
    logic        done, pass;
    logic [3:0]  err_code;
    int          errors = 0;
    int          checks = 0;

    always #2 clk = ~clk;

    vmentry_ctl_chk dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pri_ctl(pri_ctl), .sec_ctl(sec_ctl), .pri_must1(pri_must1),
        .pri_must0(pri_must0), .sec_rsvd(sec_rsvd), .cr3_cnt(cr3_cnt),
        .io_a_addr(io_a_addr), .io_b_addr(io_b_addr), .msr_addr(msr_addr),
        .vapic_addr(vapic_addr), .apic_acc_addr(apic_acc_addr),
        .tpr_thresh(tpr_thresh), .vtpr(vtpr), .paw(paw), .addr32(addr32),
        .done(done), .pass(pass), .err_code(err_code)
    );

    function automatic string tag_of(input int code);
        case (code)
            0: return "R2";  1: return "R3";  2: return "R5";  3: return "R6";
            4, 5, 6, 7, 12: return "R7";
            8: return "R9";  9: return "R10"; 10, 11: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        pri_ctl = v.pri; sec_ctl = v.sec; cr3_cnt = v.cr3;
        io_a_addr = v.io_a; io_b_addr = v.io_b; msr_addr = v.msr;
        vapic_addr = v.vapic; apic_acc_addr = v.apic;
        tpr_thresh = v.thr; vtpr = v.vt; paw = v.pw; addr32 = v.lim;
    endtask

    // start at a falling edge, then count falling edges until done (R1)
    task automatic run_check(input vec_t v, input string tag);
        int lat;
        @(negedge clk);
        apply(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!done && lat < 40);
        check("R1", "latency", lat, (v.exp_code == 0) ? 13 : int'(v.exp_code));
        check(tag, "err_code", int'(err_code), int'(v.exp_code));
        check("R2", "pass", int'(pass), (v.exp_code == 0) ? 1 : 0);
        @(negedge clk);
        check("R1", "done width", int'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        vec_t v;
        int n_done;
        repeat (3) @(negedge clk);
        check("R1", "reset done", int'(done), 0);
        check("R1", "reset pass", int'(pass), 0);
        check("R1", "reset err_code", int'(err_code), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_check(VEC[i], tag_of(int'(VEC[i].exp_code)));
        end

        // R3: must-be-one and must-be-zero masks on the primary word
        v = VEC[0];
        pri_must1 = 32'h0000_0002; v.exp_code = 4'd1; run_check(v, "R3");
        pri_must1 = 32'h8000_0000; v.exp_code = 4'd0; run_check(v, "R3");
        pri_must1 = '0; pri_must0 = 32'h0000_0008; v.exp_code = 4'd1; run_check(v, "R3");
        pri_must0 = '0;

        // R4: secondary word with reserved bits ignored when bit 31 is clear
        v = VEC[0]; v.pri = 32'h1260_0028; v.sec = 32'hFFFF_0000; v.exp_code = 4'd0;
        run_check(v, "R4");

        // R8: limit flag with an address below bit 32 is accepted
        v = VEC[0]; v.lim = 1'b1; v.exp_code = 4'd0; run_check(v, "R8");
        v.io_b = 64'h8000_0000_0000; v.pw = 6'd52; v.exp_code = 4'd5; run_check(v, "R8");

        // R13: second start and input changes during a running check
        @(negedge clk);
        v = VEC[1];
        apply(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cr3_cnt = 9'd0;
        @(negedge clk);
        start = 1'b1;
        n_done = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin
                n_done++;
                check("R13", "err_code", int'(err_code), 3);
            end
        end
        check("R13", "done count", n_done, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule